// File: doc/BRIEF.md
# Bit-serial CRC-32C engine without message augmentation

The engine computes a 32-bit cyclic redundancy check over a byte stream, one bit per clock. Bytes arrive on a valid/ready handshake that carries start and end markers. The bit order of each byte is reversed on entry. The mirrored bits then enter a divider, most significant bit first. In the default direct form, the outgoing register bit is combined with the incoming message bit. The register therefore holds the remainder as soon as the last message bit has been taken, and no zero padding is needed.

For cross-checking, a message can instead be run through plain long division. That path starts from an equivalent preset, shifts the message bits into the register, and then flushes 32 zero bits. The mode is chosen with the start marker. Both forms leave the same raw register value.

An optional output stage, chosen by a parameter, inverts and bit-reverses the result into the usual transmitted form. A one-clock strobe marks each new result.

Top module: `crc32s_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `crc_done` is 0. `crc_out` reads 0x00000000 with the output stage off and 0xFFFFFFFF with it on.
- R2: In direct mode (`in_aug`=0 on the start byte), `crc_out` with the output stage off equals the bit-reversal (bit i to bit 31-i) of the following register value: a least-significant-bit-first CRC with reflected generator 0x82F63B78 over the bytes in arrival order, preset to 0xFFFFFFFF, with no final inversion.
- R3: A byte with `in_first`=1 restarts the register from the preset, so a message's result does not depend on earlier messages.
- R4: The four 28-byte messages give the value of R2: all 0x00, all 0xFF, 0x00 rising to 0x1B, and 0x1B falling to 0x00.
- R5: In augmented mode (`in_aug`=1 on the start byte), the preset is 0x2A26F826. Each message bit is shifted in at the register's low end, the decision uses only the bit shifted out, and 32 zero bits are flushed after the last byte. The result equals the direct-mode result for the same bytes.
- R6: After each accepted byte, `in_ready` is low for exactly 8 cycles. After the last byte of an augmented message it is low for exactly 40 cycles.
- R7: `crc_done` is high for exactly one cycle. That cycle is the one in which `in_ready` returns after the last byte, which is 8 cycles after the handshake of the last byte in direct mode and 40 cycles after it in augmented mode.
- R8: `crc_out` changes only together with `crc_done` and holds its value until the next message completes.
- R9: With the output stage enabled, `crc_out` is the bitwise inverse of the R2 register value, which is the standard transmitted CRC-32C.
- R10: `in_aug` on bytes without `in_first` has no effect on the result or on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Message byte |
| in_first | input | 1 | Byte starts a message (register preset) |
| in_last | input | 1 | Byte ends a message |
| in_aug | input | 1 | Mode select on the start byte: 1 = augmented, 0 = direct |
| crc_out | output | 32 | Result of the last completed message |
| crc_done | output | 1 | One-cycle strobe when `crc_out` takes a new result |

## Verification
A corrupt register bit, a wrong feedback decision or a wrong preset cannot be seen until the message completes. It then shows as a wrong `crc_out` at the `crc_done` strobe, 8 or 40 cycles after the last byte's handshake. The bench compares that value against an independent reflected-form model in both modes and on both output forms. A wrong bit counter or flush counter shows much sooner. It alters the number of cycles `in_ready` stays low after the very next byte, and each of those windows is counted. Mirroring faults that the uniform 0x00 and 0xFF messages would hide are exposed by the rising, falling and random byte patterns.

// File: rtl/crc32s_pkg.sv
package crc32s_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BITS  = 2'd1,
      PH_FLUSH = 2'd2
   } crc32s_phase_e;
endpackage

// File: rtl/crc32s_mirror.sv
// Reverses the bit order of one input word.
module crc32s_mirror #(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/crc32s_step.sv
// One divider step. Direct form: feedback = popped bit xor message bit, a zero enters.
// Augmented form: the message bit enters at the low end, feedback = popped bit.
module crc32s_step #(
   parameter int          CRC_W = 32,
   parameter logic [31:0] POLY  = 32'h1EDC6F41
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic             msg_bit,
   input  logic             aug,
   output logic [CRC_W-1:0] crc_nxt
);
   logic             popped;
   logic             fb;
   logic [CRC_W-1:0] shifted;

   always_comb begin
      popped  = crc_in[CRC_W-1];
      shifted = {crc_in[CRC_W-2:0], aug & msg_bit};
      fb      = aug ? popped : (popped ^ msg_bit);
      crc_nxt = fb ? (shifted ^ POLY[CRC_W-1:0]) : shifted;
   end
endmodule

// File: rtl/crc32s_txform.sv
// Optional transmit form: bitwise invert and bit-reverse.
module crc32s_txform #(
   parameter int CRC_W  = 32,
   parameter bit ENABLE = 1'b0
) (
   input  logic [CRC_W-1:0] raw,
   output logic [CRC_W-1:0] tx
);
   if (ENABLE) begin : g_tx
      for (genvar i = 0; i < CRC_W; i++) begin : g_bit
         assign tx[i] = ~raw[CRC_W-1-i];
      end
   end else begin : g_raw
      assign tx = raw;
   end
endmodule

// File: rtl/crc32s_engine.sv
module crc32s_engine
   import crc32s_pkg::*;
#(
   parameter int          CRC_W         = 32,
   parameter int          BYTE_W        = 8,
   parameter logic [31:0] POLY          = 32'h1EDC6F41,
   parameter logic [31:0] PRESET_DIRECT = 32'hFFFFFFFF,
   parameter logic [31:0] PRESET_AUG    = 32'h2A26F826,
   parameter bit          TX_FINAL      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   input  logic              in_aug,
   output logic [CRC_W-1:0]  crc_out,
   output logic              crc_done
);
   localparam int BIT_CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam int FL_CW  = (CRC_W > 1) ? $clog2(CRC_W) : 1;
   localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BYTE_W - 1);
   localparam logic [FL_CW-1:0]  FL_LAST  = FL_CW'(CRC_W - 1);

   initial begin
      assert (CRC_W >= 2 && CRC_W <= 32)
         else $error("crc32s_engine: CRC_W must lie in 2..32");
      assert (BYTE_W >= 2)
         else $error("crc32s_engine: BYTE_W must be at least 2");
   end

   crc32s_phase_e     phase_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] mir;
   logic [BIT_CW-1:0] bit_q;
   logic [FL_CW-1:0]  fl_q;
   logic              last_q;
   logic              aug_q;
   logic              done_q;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  res_q;
   logic [CRC_W-1:0]  step_out;
   logic              step_bit;
   logic              accept;

   assign in_ready = (phase_q == PH_IDLE);
   assign accept   = in_valid && in_ready;
   assign step_bit = (phase_q == PH_BITS) ? sh_q[BYTE_W-1] : 1'b0;
   assign crc_done = done_q;

   crc32s_mirror #(.W(BYTE_W)) mir_i (
      .din  (in_data),
      .dout (mir)
   );

   crc32s_step #(.CRC_W(CRC_W), .POLY(POLY)) step_i (
      .crc_in  (crc_q),
      .msg_bit (step_bit),
      .aug     (aug_q),
      .crc_nxt (step_out)
   );

   crc32s_txform #(.CRC_W(CRC_W), .ENABLE(TX_FINAL)) tx_i (
      .raw (res_q),
      .tx  (crc_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sh_q    <= '0;
         bit_q   <= '0;
         fl_q    <= '0;
         last_q  <= 1'b0;
         aug_q   <= 1'b0;
         done_q  <= 1'b0;
         crc_q   <= '0;
         res_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  sh_q    <= mir;
                  bit_q   <= '0;
                  last_q  <= in_last;
                  phase_q <= PH_BITS;
                  if (in_first) begin
                     aug_q <= in_aug;
                     crc_q <= in_aug ? PRESET_AUG[CRC_W-1:0]
                                     : PRESET_DIRECT[CRC_W-1:0];
                  end
               end
            end
            PH_BITS: begin
               crc_q <= step_out;
               sh_q  <= sh_q << 1;
               bit_q <= bit_q + 1'b1;
               if (bit_q == BIT_LAST) begin
                  if (!last_q) begin
                     phase_q <= PH_IDLE;
                  end else if (aug_q) begin
                     fl_q    <= '0;
                     phase_q <= PH_FLUSH;
                  end else begin
                     res_q   <= step_out;
                     done_q  <= 1'b1;
                     phase_q <= PH_IDLE;
                  end
               end
            end
            PH_FLUSH: begin
               crc_q <= step_out;
               fl_q  <= fl_q + 1'b1;
               if (fl_q == FL_LAST) begin
                  res_q   <= step_out;
                  done_q  <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/crc32s_engine_chk.sv
module crc32s_engine_chk #(
   parameter int CRC_W  = 32,
   parameter int BYTE_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             crc_done,
   input logic [CRC_W-1:0] crc_out
);
   localparam int CW = $clog2(BYTE_W + CRC_W + 2) + 1;
   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (in_valid && in_ready) begin
         busy_cnt <= '0;
      end else if (!in_ready && busy_cnt != {CW{1'b1}}) begin
         busy_cnt <= busy_cnt + 1'b1;
      end
   end

   // R6: a handshake closes the input for the next cycle
   p_take_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R6: ready never returns before a full byte of bit steps
   p_busy_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> (busy_cnt >= CW'(BYTE_W)));

   // R7: single-cycle strobe
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done |=> !crc_done);

   // R7: result strobe coincides with ready returning
   p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done |-> in_ready);

   // R8: output moves only with the strobe
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_out) |-> crc_done);
endmodule

bind crc32s_engine crc32s_engine_chk #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .crc_done (crc_done),
   .crc_out  (crc_out)
);

// File: tb/crc32s_engine_tb.sv
module crc32s_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_first = 1'b0;
   logic        in_last = 1'b0;
   logic        in_aug = 1'b0;
   logic        in_ready, tx_ready;
   logic [31:0] crc_out, tx_crc;
   logic        crc_done, tx_done;

   int unsigned checks = 0;
   int unsigned errors = 0;
   logic [7:0]  msg [0:63];

   always #4 clk = ~clk;

   crc32s_engine dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_aug(in_aug),
      .crc_out(crc_out), .crc_done(crc_done)
   );

   crc32s_engine #(.TX_FINAL(1'b1)) dut_tx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(tx_ready),
      .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_aug(in_aug),
      .crc_out(tx_crc), .crc_done(tx_done)
   );

   function automatic logic [31:0] rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // Reflected least-significant-bit-first model, preset all ones, no final inversion
   function automatic logic [31:0] ref_state(input int len);
      logic [31:0] s = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
         s = s ^ {24'h0, msg[i]};
         for (int b = 0; b < 8; b++)
            s = s[0] ? ((s >> 1) ^ 32'h82F63B78) : (s >> 1);
      end
      return s;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send_msg(input int len, input bit aug, input bit spam, input string vtag);
      logic [31:0] st, exp_raw, exp_tx;
      int busy, exp_busy;
      string rtag;
      st      = ref_state(len);
      exp_raw = rev32(st);
      exp_tx  = ~st;
      rtag    = spam ? "R10" : (aug ? "R5" : vtag);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = msg[i];
         in_first = (i == 0);
         in_last  = (i == len - 1);
         in_aug   = (i == 0) ? aug : spam;
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         @(negedge clk);
         in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_aug = 1'b0;
         busy = 0;
         while (!in_ready && busy < 100) begin
            busy++;
            @(negedge clk);
         end
         exp_busy = (i == len - 1 && aug) ? 40 : 8;
         check(busy == exp_busy, spam ? "R10" : "R6", busy, exp_busy);
         if (i == len - 1) begin
            check(crc_done === 1'b1, "R7", {31'h0, crc_done}, 32'h1);
            check(crc_out === exp_raw, rtag, crc_out, exp_raw);
            check(tx_crc === exp_tx, "R9", tx_crc, exp_tx);
         end
      end
      @(negedge clk);
      check(crc_done === 1'b0, "R7", {31'h0, crc_done}, 32'h0);
      check(crc_out === exp_raw, "R8", crc_out, exp_raw);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R6: watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      logic [31:0] held;
      seed_init = $urandom(32'd2718);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(in_ready === 1'b1, "R1", {31'h0, in_ready}, 32'h1);
      check(crc_done === 1'b0, "R1", {31'h0, crc_done}, 32'h0);
      check(crc_out === 32'h0, "R1", crc_out, 32'h0);
      check(tx_crc === 32'hFFFFFFFF, "R1", tx_crc, 32'hFFFFFFFF);

      // R4 directed 28-byte vectors in both modes
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 28; i++) msg[i] = 8'h00;
         send_msg(28, m[0], 1'b0, "R4");
         for (int i = 0; i < 28; i++) msg[i] = 8'hFF;
         send_msg(28, m[0], 1'b0, "R4");
         for (int i = 0; i < 28; i++) msg[i] = 8'(i);
         send_msg(28, m[0], 1'b0, "R4");
         for (int i = 0; i < 28; i++) msg[i] = 8'(27 - i);
         send_msg(28, m[0], 1'b0, "R4");
      end

      // single-byte corner in both modes
      msg[0] = 8'hA5;
      send_msg(1, 1'b0, 1'b0, "R2");
      send_msg(1, 1'b1, 1'b0, "R2");

      // R10: mode bit toggled on non-start bytes of a direct message
      for (int i = 0; i < 12; i++) msg[i] = 8'($urandom);
      send_msg(12, 1'b0, 1'b1, "R2");

      // R3: repeat after a different message gives the same result
      for (int i = 0; i < 5; i++) msg[i] = 8'h3C ^ 8'(i);
      send_msg(5, 1'b1, 1'b0, "R3");
      send_msg(5, 1'b0, 1'b0, "R3");

      // R8: idle cycles leave the result in place
      held = crc_out;
      repeat (6) @(negedge clk);
      check(crc_out === held, "R8", crc_out, held);

      // random messages, random mode
      for (int n = 0; n < 24; n++) begin
         int len;
         bit mode;
         len  = 1 + int'($urandom % 40);
         mode = 1'($urandom);
         for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
         send_msg(len, mode, 1'b0, "R2");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule